// File: doc/BRIEF.md
# Multicycle Integer Multiply / Divide Unit

This block is the long-latency arithmetic engine of an integer pipeline. It takes two register-width operands and a 3-bit operation code. It returns one register-width word: either half of the double-width product, or the quotient or remainder of an integer division. Each of these comes in an unsigned form and a signed form. Multiplication is a shift-and-add over operand magnitudes and division is a restoring shift-and-subtract over magnitudes. Both produce one bit per clock, and the signs are applied in a final fix-up cycle.

The issuing stage raises `start_i` for one cycle while `busy_o` is low. The unit captures the operands and the code, keeps `busy_o` high while it works, and pulses `done_o` for one cycle once `result_o` holds the answer. The register width is the parameter `XLEN`, which may be 16, 32 or 64. Division by zero and the signed overflow case produce defined values and raise no trap.

Top module: `muldiv_unit`

## Requirements
- R1: Code 3'b000 returns the low XLEN bits of the unsigned product opa_i*opb_i.
- R2: Code 3'b001 returns the high XLEN bits of the unsigned 2*XLEN-bit product.
- R3: Code 3'b010 returns the low XLEN bits of the two's-complement product (identical to R1 bits).
- R4: Code 3'b011 returns the high XLEN bits of the signed 2*XLEN-bit product.
- R5: Code 3'b100 returns the unsigned quotient and code 3'b101 the unsigned remainder.
- R6: Code 3'b110 returns the signed quotient, truncated toward zero: positive when the operand signs agree, negative otherwise.
- R7: Code 3'b111 returns the signed remainder, whose sign follows the dividend (or is zero).
- R8: With a zero divisor, the quotient codes (100, 110) return all ones and the remainder codes (101, 111) return opa_i unchanged.
- R9: Signed division of the most negative value by -1 returns the most negative value (code 110) and zero (code 111).
- R10: A start sampled while busy_o is low raises busy_o on the next cycle. done_o rises XLEN+1 rising edges after the edge that sampled start, for exactly one cycle, with busy_o low in that cycle.
- R11: A start_i raised while busy_o is high is ignored: the running result is unaffected and no additional done_o pulse follows.
- R12: After synchronous active-low reset, busy_o, done_o and result_o are all zero.
- R13: result_o holds its value between done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a new operation (taken only when idle) |
| op_i | input | 3 | Operation code: bit2 divide, bit1 signed, bit0 high half / remainder |
| opa_i | input | XLEN | Multiplicand or dividend |
| opb_i | input | XLEN | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result_o valid |
| result_o | output | XLEN | Result of the last completed operation |

## Verification
Each code is run on mixed-sign operand pairs. Positive-only pairs cannot tell the signed forms from the unsigned ones, and mixed signs separate the two product halves and show whether the signs are applied to the quotient and to the remainder independently. Extreme values are included: all ones, the most negative value, -1, and a zero divisor. These check the carry out of the top product bit, the single signed overflow case and the defined divide-by-zero results. Separate sequences measure the start-to-done latency, send a second start while the unit is busy, and watch the result between completions.

// File: rtl/muldiv_pkg.sv
// Package: shared operation code type for the multiply/divide unit.
// Assumes: bit 2 selects divide, bit 1 selects signed, bit 0 selects high half or remainder.
package muldiv_pkg;

    typedef enum logic [2:0] {
        MD_MULLU = 3'b000,
        MD_MULHU = 3'b001,
        MD_MULLS = 3'b010,
        MD_MULHS = 3'b011,
        MD_DIVU  = 3'b100,
        MD_REMU  = 3'b101,
        MD_DIVS  = 3'b110,
        MD_REMS  = 3'b111
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

    function automatic logic op_is_div(input md_op_e op);
        return op[2];
    endfunction

    function automatic logic op_is_signed(input md_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_upper(input md_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/md_prep.sv
// Module: md_prep
// Computes operand magnitudes and the sign flags used by the final fix-up.
// Assumes: a two's-complement negation of the most negative value yields the
// same bit pattern, which as an unsigned magnitude is exactly 2**(XLEN-1).
module md_prep
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  md_op_e            op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   mag_a,
    output logic [XLEN-1:0]   mag_b,
    output logic              neg_res,
    output logic              neg_rem,
    output logic              b_zero
);
    logic sa, sb;

    // Operand signs are only meaningful for the signed codes.
    always_comb begin
        sa      = op_is_signed(op) & a[XLEN-1];
        sb      = op_is_signed(op) & b[XLEN-1];
        mag_a   = sa ? (~a + 1'b1) : a;
        mag_b   = sb ? (~b + 1'b1) : b;
        neg_res = sa ^ sb;
        neg_rem = sa;
        b_zero  = (b == '0);
    end
endmodule

// File: rtl/md_step.sv
// Module: md_step
// One iteration of either the shift-add multiplier or the restoring divider.
// Assumes: for division hi < m on entry, so the new remainder fits in XLEN bits.
// The generate block picks the divider or the multiplier datapath.
module md_step #(
    parameter int XLEN   = 32,
    parameter bit DIVIDE = 1'b0
) (
    input  logic [XLEN-1:0] hi,
    input  logic [XLEN-1:0] lo,
    input  logic [XLEN-1:0] m,
    output logic [XLEN-1:0] hi_nx,
    output logic [XLEN-1:0] lo_nx
);
    generate
        if (DIVIDE) begin : g_div
            logic [XLEN:0] rem_sh;
            logic [XLEN:0] diff;
            logic          ge;
            // Shift the next dividend bit in and subtract when it fits.
            always_comb begin
                rem_sh = {hi, lo[XLEN-1]};
                diff   = rem_sh - {1'b0, m};
                ge     = (rem_sh >= {1'b0, m});
                hi_nx  = ge ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];
                lo_nx  = {lo[XLEN-2:0], ge};
            end
        end else begin : g_mul
            logic [XLEN:0] sum;
            // Add the multiplicand under the current multiplier bit, shift right.
            always_comb begin
                sum   = {1'b0, hi} + (lo[0] ? {1'b0, m} : '0);
                hi_nx = sum[XLEN:1];
                lo_nx = {sum[0], lo[XLEN-1:1]};
            end
        end
    endgenerate
endmodule

// File: rtl/md_fix.sv
// Module: md_fix
// Applies signs to the magnitude result and picks the requested word.
// Assumes: {hi,lo} is the unsigned product for multiplies; for divides lo is
// the quotient magnitude and hi the remainder magnitude.
module md_fix
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  md_op_e            op,
    input  logic [XLEN-1:0]   hi,
    input  logic [XLEN-1:0]   lo,
    input  logic              neg_res,
    input  logic              neg_rem,
    input  logic              b_zero,
    input  logic [XLEN-1:0]   a_raw,
    output logic [XLEN-1:0]   result
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   prod;
    logic [XLEN-1:0] quot;
    logic [XLEN-1:0] rem;

    // Negate the selected magnitude, then choose between product half, quotient and remainder.
    always_comb begin
        prod = neg_res ? (~{hi, lo} + 1'b1) : {hi, lo};
        quot = neg_res ? (~lo + 1'b1) : lo;
        rem  = neg_rem ? (~hi + 1'b1) : hi;
        if (!op_is_div(op)) begin
            result = op_is_upper(op) ? prod[PW-1:XLEN] : prod[XLEN-1:0];
        end else if (b_zero) begin
            result = op_is_upper(op) ? a_raw : '1;
        end else begin
            result = op_is_upper(op) ? rem : quot;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
// Module: muldiv_unit (top)
// Multicycle multiply/divide unit: one capture cycle, XLEN iteration cycles,
// one sign fix-up cycle, then a one-cycle done pulse.
// Assumes: XLEN is 16, 32 or 64; start_i is honoured only while busy_o is low.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam int CW = $clog2(XLEN + 1);
    localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

    md_state_e       state_q;
    logic [CW-1:0]   cnt_q;
    md_op_e          op_q;
    logic [XLEN-1:0] hi_q, lo_q, m_q, a_q;
    logic            neg_res_q, neg_rem_q, bz_q;
    logic            done_q;
    logic [XLEN-1:0] res_q;

    md_op_e          op_in;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            neg_res, neg_rem, b_zero;
    logic [XLEN-1:0] mhi, mlo, dhi, dlo;
    logic [XLEN-1:0] fix_res;

    assign op_in = md_op_e'(op_i);

    md_prep #(.XLEN(XLEN)) u_prep (
        .op(op_in), .a(opa_i), .b(opb_i),
        .mag_a(mag_a), .mag_b(mag_b),
        .neg_res(neg_res), .neg_rem(neg_rem), .b_zero(b_zero)
    );

    md_step #(.XLEN(XLEN), .DIVIDE(1'b0)) u_mstep (
        .hi(hi_q), .lo(lo_q), .m(m_q), .hi_nx(mhi), .lo_nx(mlo)
    );

    md_step #(.XLEN(XLEN), .DIVIDE(1'b1)) u_dstep (
        .hi(hi_q), .lo(lo_q), .m(m_q), .hi_nx(dhi), .lo_nx(dlo)
    );

    md_fix #(.XLEN(XLEN)) u_fix (
        .op(op_q), .hi(hi_q), .lo(lo_q),
        .neg_res(neg_res_q), .neg_rem(neg_rem_q), .b_zero(bz_q),
        .a_raw(a_q), .result(fix_res)
    );

    // Sequencer: capture on an idle start, iterate XLEN times, fix up, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            op_q      <= MD_MULLU;
            hi_q      <= '0;
            lo_q      <= '0;
            m_q       <= '0;
            a_q       <= '0;
            neg_res_q <= 1'b0;
            neg_rem_q <= 1'b0;
            bz_q      <= 1'b0;
            done_q    <= 1'b0;
            res_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q   <= ST_RUN;
                        cnt_q     <= '0;
                        op_q      <= op_in;
                        a_q       <= opa_i;
                        neg_res_q <= neg_res;
                        neg_rem_q <= neg_rem;
                        bz_q      <= b_zero;
                        if (op_is_div(op_in)) begin
                            hi_q <= '0;
                            lo_q <= mag_a;
                            m_q  <= mag_b;
                        end else begin
                            hi_q <= '0;
                            lo_q <= mag_b;
                            m_q  <= mag_a;
                        end
                    end
                end
                ST_RUN: begin
                    hi_q  <= op_is_div(op_q) ? dhi : mhi;
                    lo_q  <= op_is_div(op_q) ? dlo : mlo;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    res_q   <= fix_res;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign result_o = res_q;
endmodule

// File: rtl/muldiv_checker.sv
// Module: muldiv_checker
// Protocol properties of muldiv_unit, attached through bind.
// Assumes: latency is counted with a local counter, not a parameter-length delay.
module muldiv_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o
);
    localparam int LW = $clog2(XLEN + 4) + 1;
    localparam logic [LW-1:0] DONE_AT = LW'(XLEN + 2);

    logic [LW-1:0] edges_q;

    // Count edges since the accepted start, the start edge included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else if (start_i && !busy_o) begin
            edges_q <= LW'(1);
        end else if (done_o) begin
            edges_q <= '0;
        end else if (edges_q != '0) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (edges_q == DONE_AT));

    assert_no_stray_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == '0) |-> !done_o);

    assert_result_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o)));
endmodule

bind muldiv_unit muldiv_checker #(.XLEN(XLEN)) u_muldiv_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   op_i = 3'b000;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] result_o;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    muldiv_unit #(.XLEN(W)) i_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] pu;
        longint         sa, sb, ps;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        pu = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        ps = sa * sb;
        case (op)
            3'b000: return pu[W-1:0];
            3'b001: return pu[2*W-1:W];
            3'b010: return ps[W-1:0];
            3'b011: return ps[2*W-1:W];
            3'b100: return (b == 0) ? '1 : a / b;
            3'b101: return (b == 0) ? a : a % b;
            3'b110: return (b == 0) ? '1 : W'(sa / sb);
            default: return (b == 0) ? a : W'(sa % sb);
        endcase
    endfunction

    // Driver: wait for idle, pulse start, push the expected result.
    task automatic issue(input string tag, input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        while (busy_o || done_o) @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; start_i = 1'b1;
        exp_q.push_back(model(op, a, b));
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each completion against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R11: actual extra done (result %h) expected none", result_o);
            end else begin
                check(tag_q.pop_front(), result_o, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    initial begin
        repeat (3) @(negedge clk);
        check("R12 busy", W'(busy_o), '0);
        check("R12 done", W'(done_o), '0);
        check("R12 result", result_o, '0);
        rst_n = 1'b1;

        // R1 / R3 low product, R2 / R4 high product, mixed signs
        issue("R1 mullu", 3'b000, 32'h1234_5678, 32'h9abc_def0);
        issue("R1 mullu ones", 3'b000, '1, '1);
        issue("R2 mulhu ones", 3'b001, '1, '1);
        issue("R2 mulhu", 3'b001, 32'h8000_0001, 32'h0001_0003);
        issue("R3 mulls neg", 3'b010, 32'hffff_fffd, 32'h0000_0007);
        issue("R3 mulls min", 3'b010, MINV, MINV);
        issue("R4 mulhs neg*pos", 3'b011, 32'hffff_fffd, 32'h7fff_ffff);
        issue("R4 mulhs min*min", 3'b011, MINV, MINV);
        issue("R4 mulhs -1*-1", 3'b011, '1, '1);
        // R5 unsigned division
        issue("R5 divu", 3'b100, 32'hffff_fff0, 32'h0000_0007);
        issue("R5 remu", 3'b101, 32'hffff_fff0, 32'h0000_0007);
        issue("R5 divu big divisor", 3'b100, 32'h0000_0005, 32'h8000_0000);
        // R6 / R7 signed division, all sign pairs
        issue("R6 divs -7/2", 3'b110, -32'sd7, 32'sd2);
        issue("R6 divs 7/-2", 3'b110, 32'sd7, -32'sd2);
        issue("R6 divs -7/-2", 3'b110, -32'sd7, -32'sd2);
        issue("R7 rems -7/2", 3'b111, -32'sd7, 32'sd2);
        issue("R7 rems 7/-2", 3'b111, 32'sd7, -32'sd2);
        issue("R7 rems -7/-2", 3'b111, -32'sd7, -32'sd2);
        // R8 zero divisor
        issue("R8 divu by 0", 3'b100, 32'h0000_1234, '0);
        issue("R8 remu by 0", 3'b101, 32'h0000_1234, '0);
        issue("R8 divs neg by 0", 3'b110, -32'sd9, '0);
        issue("R8 rems neg by 0", 3'b111, -32'sd9, '0);
        // R9 signed overflow
        issue("R9 divs min/-1", 3'b110, MINV, '1);
        issue("R9 rems min/-1", 3'b111, MINV, '1);
        drain();

        // R10 latency and busy
        begin
            int n;
            @(negedge clk);
            op_i = 3'b100; opa_i = 32'd100; opb_i = 32'd7; start_i = 1'b1;
            exp_q.push_back(32'd14); tag_q.push_back("R10 result");
            @(negedge clk);
            start_i = 1'b0;
            n = 1;
            check("R10 busy after start", W'(busy_o), W'(1));
            while (!done_o && n < 200) begin
                @(negedge clk);
                n++;
            end
            check("R10 latency edges", W'(n), W'(W + 2));
            check("R10 busy low at done", W'(busy_o), '0);
        end
        drain();

        // R11 start while busy ignored
        issue("R11 first op kept", 3'b010, 32'd6, -32'sd5);
        repeat (3) @(negedge clk);
        op_i = 3'b001; opa_i = '1; opb_i = '1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        repeat (W + 8) @(negedge clk);

        // R13 hold between completions
        begin
            logic [W-1:0] held;
            held = result_o;
            repeat (10) @(negedge clk);
            check("R13 result held", result_o, held);
        end

        check("scoreboard empty", W'(exp_q.size()), '0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule